// File: doc/BRIEF.md
# Interrupt Routing and Gating Controller

This block sits beside a host bridge and decides which of its interrupt request lines may reach the interrupt-vector outputs. It takes 48 level-sensitive requests. Lines 0 to 31 come from expansion slots, and each group of four consecutive lines shares one slot map register. Lines 32 to 47 come from on-board devices, and each of these lines has its own board map register. Each map register holds a read-only routing identifier and a single writable enable. While the enable is set, the registered output follows its request. While the enable is clear, the output is held low.

Software reaches the registers through a simple request port. Every register occupies an 8-byte slot and answers only on the upper 32-bit word of that slot. Two further address windows act as clear strobes. A write there pulls one output line low for a single cycle. Reset clears every enable but leaves the routing identifiers in place. The identifiers are fixed values, so they are generated from logic rather than stored in flops.

Top module: `irq_route_ctrl`

## Requirements
- R1: Line n (0..31) is governed by slot map register n>>2. Line n (32..47) is governed by board map register n-32.
- R2: One clock edge after any input change, irq_o[n] equals irq_i[n] when the governing enable is 1, and 0 when it is 0.
- R3: Slot map register i (0..7) is at offset 0x0C04+8*i. Board map register i (0..15) is at offset 0x1004+8*i. The register index is (offset-base)>>3.
- R4: When offset bit 2 is 0, a read returns 0 and a write changes nothing, including writes inside the clear windows.
- R5: Register word layout: bit 31 is the enable and is the only writable bit. Bits 30:0 are read-only and hold 0x7C0|(i<<2) for slot register i and 0x7E0+i for board register i.
- R6: A write to offset 0x1400+8*k+4 (k 0..7) forces irq_o[k] low at the next edge. A write to 0x1804+8*k (k 0..11) does the same for irq_o[32+k]. The write data is ignored, and the line returns on the following edge if its input is high and its line is enabled.
- R7: Asynchronous reset (rst_ni low) clears all enables, irq_o and rdata_o. The routing identifiers read back unchanged after reset.
- R8: rdata_o is updated at the clock edge that samples a read request and holds its value otherwise. Offsets outside the map windows read 0 and ignore writes.
- R9: A write to an enable changes the affected outputs at the second clock edge after the write is sampled, not the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 48 | Raw level interrupt requests |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 16 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 48 | Gated interrupt lines, registered |

## Verification
The bench drives inputs on falling edges and samples outputs on falling edges, so each expected value lands on a known edge count. Read data and request-driven gating are due one edge after they are sampled, and the bench checks both at the next falling edge. Enable writes go through two registers, so the bench first confirms that the affected line is still low one edge after the write, then confirms it is high one edge later. Clear strobes are checked twice: low on the first falling edge after the strobe, and high again on the one after that.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SLOT_SH = 3;
  localparam int unsigned UPPER_B = 2;

  localparam logic [OFF_W-1:0] SLOT_MAP_LO = 16'h0C00;
  localparam logic [OFF_W-1:0] SLOT_MAP_HI = 16'h0C3F;
  localparam logic [OFF_W-1:0] BRD_MAP_LO  = 16'h1000;
  localparam logic [OFF_W-1:0] BRD_MAP_HI  = 16'h1080;
  localparam logic [OFF_W-1:0] SLOT_CLR_LO = 16'h1400;
  localparam logic [OFF_W-1:0] SLOT_CLR_HI = 16'h143F;
  localparam logic [OFF_W-1:0] BRD_CLR_LO  = 16'h1800;
  localparam logic [OFF_W-1:0] BRD_CLR_HI  = 16'h1860;

  localparam logic [DATA_W-2:0] ID_GROUP = 31'h7C0;
  localparam logic [DATA_W-2:0] BRD_TAG  = 31'h020;

  function automatic logic in_win(input logic [OFF_W-1:0] off,
                                  input logic [OFF_W-1:0] lo,
                                  input logic [OFF_W-1:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction

  function automatic logic [OFF_W-1:0] slot_of(input logic [OFF_W-1:0] off,
                                                input logic [OFF_W-1:0] lo);
    return (off - lo) >> SLOT_SH;
  endfunction

  function automatic logic [DATA_W-2:0] slot_id(input int unsigned i);
    return ID_GROUP | (31'(i) << 2);
  endfunction

  function automatic logic [DATA_W-2:0] brd_id(input int unsigned i);
    return (ID_GROUP | BRD_TAG) + 31'(i);
  endfunction
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SLOT_MAP = 8,
  parameter int unsigned N_BRD_MAP  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [OFF_W-1:0]      off_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [N_SLOT_MAP-1:0] slot_en_o,
  output logic [N_BRD_MAP-1:0]  brd_en_o
);
  logic              upper;
  logic              slot_hit, brd_hit;
  logic [OFF_W-1:0]  slot_idx, brd_idx;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic [N_SLOT_MAP-1:0] slot_en_q;
  logic [N_BRD_MAP-1:0]  brd_en_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-2:0];

  assign upper    = off_i[UPPER_B];
  assign slot_idx = slot_of(off_i, SLOT_MAP_LO);
  assign brd_idx  = slot_of(off_i, BRD_MAP_LO);
  assign slot_hit = req_i && upper && in_win(off_i, SLOT_MAP_LO, SLOT_MAP_HI);
  assign brd_hit  = req_i && upper && in_win(off_i, BRD_MAP_LO, BRD_MAP_HI);

  for (genvar i = 0; i < N_SLOT_MAP; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_en_q[i] <= 1'b0;
      else if (slot_hit && we_i && slot_idx == OFF_W'(i))
        slot_en_q[i] <= wdata_i[DATA_W-1];
    end
  end

  for (genvar i = 0; i < N_BRD_MAP; i++) begin : g_brd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) brd_en_q[i] <= 1'b0;
      else if (brd_hit && we_i && brd_idx == OFF_W'(i))
        brd_en_q[i] <= wdata_i[DATA_W-1];
    end
  end

  // identifiers are constants: only the enable is stored
  always_comb begin
    rd_val = '0;
    for (int unsigned i = 0; i < N_SLOT_MAP; i++)
      if (slot_hit && slot_idx == OFF_W'(i)) rd_val = {slot_en_q[i], slot_id(i)};
    for (int unsigned i = 0; i < N_BRD_MAP; i++)
      if (brd_hit && brd_idx == OFF_W'(i)) rd_val = {brd_en_q[i], brd_id(i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_val;
  end

  assign rdata_o   = rdata_q;
  assign slot_en_o = slot_en_q;
  assign brd_en_o  = brd_en_q;

  assert_lower_word_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !off_i[UPPER_B]) |=> ($stable(slot_en_o) && $stable(brd_en_o)));
  assert_lower_word_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !off_i[UPPER_B]) |=> (rdata_o == '0));
  assert_rdata_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  assert_id_readonly_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off_i == SLOT_MAP_LO + 16'h4) |=> (rdata_o[DATA_W-2:0] == 31'h7C0));
endmodule

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SLOT_LINES = 32,
  parameter int unsigned N_LINES      = 48
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [N_LINES-1:0] clr_o
);
  logic             strobe;
  logic             slot_win, brd_win;
  logic [OFF_W-1:0] slot_k, brd_k;

  assign strobe   = req_i && we_i && off_i[UPPER_B];
  assign slot_win = strobe && in_win(off_i, SLOT_CLR_LO, SLOT_CLR_HI);
  assign brd_win  = strobe && in_win(off_i, BRD_CLR_LO, BRD_CLR_HI);
  assign slot_k   = slot_of(off_i, SLOT_CLR_LO);
  assign brd_k    = slot_of(off_i, BRD_CLR_LO);

  for (genvar n = 0; n < N_LINES; n++) begin : g_clr
    if (n < N_SLOT_LINES) begin : g_s
      assign clr_o[n] = slot_win && slot_k == OFF_W'(n);
    end else begin : g_b
      assign clr_o[n] = brd_win && brd_k == OFF_W'(n - N_SLOT_LINES);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N_SLOT_MAP  = 8,
  parameter int unsigned SLOT_PER_MAP = 4,
  parameter int unsigned N_BRD_MAP   = 16,
  localparam int unsigned N_SLOT_LINES = N_SLOT_MAP * SLOT_PER_MAP,
  localparam int unsigned N_LINES      = N_SLOT_LINES + N_BRD_MAP
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_LINES-1:0]    irq_i,
  input  logic [N_SLOT_MAP-1:0] slot_en_i,
  input  logic [N_BRD_MAP-1:0]  brd_en_i,
  input  logic [N_LINES-1:0]    clr_i,
  output logic [N_LINES-1:0]    irq_o
);
  logic [N_LINES-1:0] en_line;
  logic [N_LINES-1:0] out_q;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    if (n < N_SLOT_LINES) begin : g_s
      assign en_line[n] = slot_en_i[n / SLOT_PER_MAP];
    end else begin : g_b
      assign en_line[n] = brd_en_i[n - N_SLOT_LINES];
    end
  end

  // clear strobe outranks the request for exactly one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= irq_i & en_line & ~clr_i;
  end

  assign irq_o = out_q;

  assert_disabled_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(en_line)) == '0));
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(irq_i)) == '0));
  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((irq_o & $past(clr_i)) == '0));
  assert_clear_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SLOT_MAP   = 8,
  parameter int unsigned SLOT_PER_MAP = 4,
  parameter int unsigned N_BRD_MAP    = 16
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic [N_SLOT_MAP*SLOT_PER_MAP+N_BRD_MAP-1:0] irq_i,
  input  logic                                         req_i,
  input  logic                                         we_i,
  input  logic [15:0]                                  off_i,
  input  logic [31:0]                                  wdata_i,
  output logic [31:0]                                  rdata_o,
  output logic [N_SLOT_MAP*SLOT_PER_MAP+N_BRD_MAP-1:0] irq_o
);
  localparam int unsigned N_SLOT_LINES = N_SLOT_MAP * SLOT_PER_MAP;
  localparam int unsigned N_LINES      = N_SLOT_LINES + N_BRD_MAP;

  logic [N_SLOT_MAP-1:0] slot_en;
  logic [N_BRD_MAP-1:0]  brd_en;
  logic [N_LINES-1:0]    clr;

  irq_map_regs #(.N_SLOT_MAP(N_SLOT_MAP), .N_BRD_MAP(N_BRD_MAP)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .off_i, .wdata_i,
    .rdata_o, .slot_en_o(slot_en), .brd_en_o(brd_en)
  );

  irq_clr_decode #(.N_SLOT_LINES(N_SLOT_LINES), .N_LINES(N_LINES)) u_clr (
    .req_i, .we_i, .off_i, .clr_o(clr)
  );

  irq_gate #(.N_SLOT_MAP(N_SLOT_MAP), .SLOT_PER_MAP(SLOT_PER_MAP), .N_BRD_MAP(N_BRD_MAP)) u_gate (
    .clk_i, .rst_ni, .irq_i, .slot_en_i(slot_en), .brd_en_i(brd_en),
    .clr_i(clr), .irq_o
  );

  assert_enable_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && off_i == 16'h0C04 && wdata_i[31] && !slot_en[0] && (&irq_i[3:0]))
      |=> (irq_o[3:0] == $past(irq_o[3:0] & irq_i[3:0])));
endmodule

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  localparam int NL = 48;
  localparam int NV = 15;
  // {we, offset, wdata, expected read data}
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 16'h0C04, 32'h0, 32'h0000_07C0},
    {1'b0, 16'h0C3C, 32'h0, 32'h0000_07DC},
    {1'b0, 16'h0C00, 32'h0, 32'h0000_0000},
    {1'b1, 16'h0C0C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 16'h0C0C, 32'h0, 32'h8000_07C4},
    {1'b1, 16'h0C08, 32'h0, 32'h0},
    {1'b0, 16'h0C0C, 32'h0, 32'h8000_07C4},
    {1'b0, 16'h1004, 32'h0, 32'h0000_07E0},
    {1'b0, 16'h107C, 32'h0, 32'h0000_07EF},
    {1'b1, 16'h1014, 32'h8000_0000, 32'h0},
    {1'b0, 16'h1014, 32'h0, 32'h8000_07E2},
    {1'b0, 16'h2004, 32'h0, 32'h0000_0000},
    {1'b1, 16'h1014, 32'h0000_0123, 32'h0},
    {1'b0, 16'h1014, 32'h0, 32'h0000_07E2},
    {1'b0, 16'h1084, 32'h0, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] irq = '0;
  logic req = 1'b0, we = 1'b0;
  logic [15:0] off = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [NL-1:0] irq_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_route_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .off_i(off), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk48(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; off = o; wd = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  localparam logic [NL-1:0] MAP1 = 48'h0000_0000_00F0;
  localparam logic [NL-1:0] L37  = 48'h0020_0000_0000;

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk48("R7 reset irq_o", irq_out, '0);
    chk32("R7 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][80], VEC[i][79:64], VEC[i][63:32]);
      if (!VEC[i][80]) chk32($sformatf("R3 R4 R5 R8 row %0d", i), rdata, VEC[i][31:0]);
    end

    irq = '1;
    @(negedge clk);
    chk48("R2 only map1 lines pass", irq_out, MAP1);
    irq = 48'h40;
    @(negedge clk);
    chk48("R1 line 6 via slot map 1", irq_out, 48'h40);
    irq = 48'h100;
    @(negedge clk);
    chk48("R1 line 8 via disabled slot map 2", irq_out, '0);
    irq = 48'h0010_0000_0000;
    @(negedge clk);
    chk48("R1 line 36 via disabled board map 4", irq_out, '0);
    irq = '1;
    @(negedge clk);

    bus(1'b1, 16'h102C, 32'h8000_0000);
    chk48("R9 not yet after one edge", irq_out, MAP1);
    @(negedge clk);
    chk48("R9 board map 5 enables line 37", irq_out, MAP1 | L37);

    bus(1'b1, 16'h142C, 32'h0);
    chk48("R6 slot clear line 5 low", irq_out, (MAP1 | L37) & ~48'h20);
    @(negedge clk);
    chk48("R6 line 5 reasserts", irq_out, MAP1 | L37);

    bus(1'b1, 16'h182C, 32'hFFFF_FFFF);
    chk48("R6 board clear line 37 low", irq_out, MAP1);
    @(negedge clk);
    chk48("R6 line 37 reasserts", irq_out, MAP1 | L37);

    bus(1'b1, 16'h1428, 32'h0);
    chk48("R4 lower-word clear ignored", irq_out, MAP1 | L37);
    bus(1'b1, 16'h1028, 32'h0);
    @(negedge clk);
    chk48("R4 lower-word enable write ignored", irq_out, MAP1 | L37);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk48("R7 async reset clears irq_o", irq_out, '0);
    chk32("R7 async reset clears rdata", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus(1'b0, 16'h0C0C, 32'h0);
    chk32("R7 id kept, enable cleared", rdata, 32'h0000_07C4);
    chk48("R7 lines stay disabled", irq_out, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule